// File: doc/BRIEF.md
# Parallel LFSR Step Unit

A purely combinational unit that advances a linear-feedback shift register by `DATA_W` single-bit steps in one evaluation. It takes the present register contents and a word of input bits, and it returns the register contents after those steps together with the bit produced at each step. The register width, the polynomial, the feedback arrangement (Fibonacci or Galois), the bit order and a feed-forward option are all fixed by parameters.

The unit is the shared core of pattern generators, scramblers, descramblers and CRC engines. The surrounding wrapper holds the state register and supplies it back on `state_in` each cycle. Enables, reset, seeding and any final CRC inversion also belong to that wrapper. With `data_in` tied to zero and Fibonacci feedback, the unit produces a pseudorandom bit sequence. With Galois feedback and message bits on `data_in`, it computes a running CRC remainder.

Top module: `lfsr_step`

## Requirements
- R1: `POLY` has `STATE_W` bits and the highest-order term is implied by the width. In Fibonacci mode, polynomial bit k (k of 1 or more) taps stage k-1, and bit 0 taps the top stage `STATE_W-1`. In Galois mode, polynomial bit k (k of 1 or more) marks stage k as an XOR point.
- R2: In a Fibonacci step, the output bit is the input bit XORed with the parity of the tapped stages. All stages move one place toward the higher index, and the output bit enters stage 0.
- R3: In a Galois step, the output bit is the top stage XORed with the input bit. The register moves one place toward the higher index, the output bit enters stage 0, and it is XORed into every stage marked in the polynomial.
- R4: With `FEED_FWD` set, the raw input bit enters stage 0 (and the Galois XOR points) in place of the output bit. The output bit formula is unchanged, which makes the unit a self-synchronising descrambler.
- R5: With `REVERSE` clear, step i (0 first) consumes `data_in[DATA_W-1-i]` and writes its output to `data_out[DATA_W-1-i]`. Bit k of `state_in` and `state_out` is stage k. A Fibonacci step is a pure shift of the upper stages.
- R6: With `REVERSE` set, all four ports are bit-reversed against R5. Step i then consumes `data_in[i]` and writes `data_out[i]`, and port bit k of the state is stage `STATE_W-1-k`.
- R7: One evaluation equals `DATA_W` consecutive single steps, for `DATA_W` of 1, 8 and 64, in both feedback modes, with and without feed-forward.
- R8: With Fibonacci feedback, `data_in` at zero and the state fed back from an all-ones start, polynomial `9'h021` yields the PRBS9 stream and `31'h10000001` yields the PRBS31 stream. Each byte equals the low eight stages after eight steps.
- R9: With Galois feedback, `REVERSE` set, polynomial `32'h04c11db7` and an all-ones start, feeding the ASCII bytes "123456789" leaves `state_out` at `32'h340BC6D9`. This is the Ethernet CRC32 before its final inversion.
- R10: A zero state with zero input gives zero on both outputs in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | DATA_W | Input bits consumed by the steps (zero for pattern generation) |
| state_in | input | STATE_W | Register contents before the steps |
| data_out | output | DATA_W | Bit produced by each step |
| state_out | output | STATE_W | Register contents after the steps |

## Verification
The bench builds seven copies of the unit. It uses Fibonacci and Galois feedback at widths 7, 9, 16, 23, 31, 32 and 58, step counts of 1, 8 and 64, and feed-forward and reversed variants. Together these cover every mode combination against a bit-serial model on random states and inputs. The 31-bit and 9-bit Fibonacci copies, chained through their own state output, reach long stretches of the PRBS31 and PRBS9 streams, including the case where 64 steps exceed the 9-stage register. The reversed 32-bit Galois copy brings the standard CRC32 check value within reach.

// File: rtl/lfsr_step.sv
module lfsr_step #(
  parameter int                 STATE_W  = 31,
  parameter logic [STATE_W-1:0] POLY     = 31'h10000001,
  parameter bit                 GALOIS   = 1'b0,
  parameter bit                 FEED_FWD = 1'b0,
  parameter bit                 REVERSE  = 1'b0,
  parameter int                 DATA_W   = 8
) (
  input  logic [DATA_W-1:0]  data_in,
  input  logic [STATE_W-1:0] state_in,
  output logic [DATA_W-1:0]  data_out,
  output logic [STATE_W-1:0] state_out
);

  // Fibonacci tap mask: poly bit k taps stage k-1, bit 0 taps the top stage
  localparam logic [STATE_W-1:0] TAPS  = {POLY[0], POLY[STATE_W-1:1]};
  // Galois injection mask: stage 0 always, plus every marked stage
  localparam logic [STATE_W-1:0] GMASK = {POLY[STATE_W-1:1], 1'b1};

  logic [STATE_W-1:0] st;
  logic [DATA_W-1:0]  din;
  logic [DATA_W-1:0]  dout;
  logic               bit_in, fb, obit, inj;

  always_comb begin
    for (int k = 0; k < STATE_W; k++)
      st[k] = REVERSE ? state_in[STATE_W-1-k] : state_in[k];
    for (int k = 0; k < DATA_W; k++)
      din[k] = REVERSE ? data_in[DATA_W-1-k] : data_in[k];
    dout   = '0;
    bit_in = 1'b0;
    fb     = 1'b0;
    obit   = 1'b0;
    inj    = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      bit_in = din[DATA_W-1-i];
      fb     = GALOIS ? st[STATE_W-1] : ^(st & TAPS);
      obit   = fb ^ bit_in;
      inj    = FEED_FWD ? bit_in : obit;
      if (GALOIS)
        st = {st[STATE_W-2:0], 1'b0} ^ (inj ? GMASK : '0);
      else
        st = {st[STATE_W-2:0], inj};
      dout[DATA_W-1-i] = obit;
    end
    for (int k = 0; k < STATE_W; k++)
      state_out[k] = REVERSE ? st[STATE_W-1-k] : st[k];
    for (int k = 0; k < DATA_W; k++)
      data_out[k] = REVERSE ? dout[DATA_W-1-k] : dout[k];
  end

  always_comb begin
    if (state_in == '0 && data_in == '0)
      assert_zero_lock_R10: assert (state_out == '0 && data_out == '0)
        else $error("zero state and input did not stay zero");
  end

  if (!GALOIS && !REVERSE && DATA_W < STATE_W) begin : g_fib_shift
    always_comb
      assert_upper_shift_R5: assert (state_out[STATE_W-1:DATA_W] == state_in[STATE_W-1-DATA_W:0])
        else $error("upper stages did not shift by DATA_W");
  end

  if (!GALOIS && !FEED_FWD && !REVERSE && DATA_W <= STATE_W) begin : g_fib_out
    always_comb
      assert_fib_out_in_state_R2: assert (state_out[DATA_W-1:0] == data_out)
        else $error("Fibonacci output bits are not the bits shifted in");
  end

  if (!GALOIS && FEED_FWD && !REVERSE && DATA_W <= STATE_W) begin : g_fib_ff
    always_comb
      assert_ff_raw_in_R4: assert (state_out[DATA_W-1:0] == data_in)
        else $error("feed-forward did not shift in the raw input");
  end

  if (GALOIS && !REVERSE) begin : g_gal_first
    always_comb
      assert_galois_first_R3: assert (data_out[DATA_W-1] == (state_in[STATE_W-1] ^ data_in[DATA_W-1]))
        else $error("first Galois output is not top stage xor input");
  end

  if (GALOIS && REVERSE) begin : g_gal_rev
    always_comb
      assert_galois_rev_first_R6: assert (data_out[0] == (state_in[0] ^ data_in[0]))
        else $error("reversed first Galois output misplaced");
  end

endmodule

// File: tb/lfsr_step_tb.sv
module lfsr_step_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // A: Fibonacci 31, 8 steps
  logic [30:0] a_si, a_so;  logic [7:0]  a_di, a_do;
  // B: Fibonacci 9, 64 steps
  logic [8:0]  b_si, b_so;  logic [63:0] b_di, b_do;
  // C: Galois 32 reversed, 8 steps
  logic [31:0] c_si, c_so;  logic [7:0]  c_di, c_do;
  // D: Galois 16, 1 step
  logic [15:0] d_si, d_so;  logic [0:0]  d_di, d_do;
  // E: Fibonacci 58 feed-forward reversed, 64 steps
  logic [57:0] e_si, e_so;  logic [63:0] e_di, e_do;
  // F: Galois 23 feed-forward, 64 steps
  logic [22:0] f_si, f_so;  logic [63:0] f_di, f_do;
  // G: Fibonacci 7, 1 step
  logic [6:0]  g_si, g_so;  logic [0:0]  g_di, g_do;

  lfsr_step #(.STATE_W(31), .POLY(31'h10000001), .GALOIS(1'b0), .FEED_FWD(1'b0), .REVERSE(1'b0), .DATA_W(8))
    u_dut (.data_in(a_di), .state_in(a_si), .data_out(a_do), .state_out(a_so));
  lfsr_step #(.STATE_W(9), .POLY(9'h021), .GALOIS(1'b0), .FEED_FWD(1'b0), .REVERSE(1'b0), .DATA_W(64))
    u_p9 (.data_in(b_di), .state_in(b_si), .data_out(b_do), .state_out(b_so));
  lfsr_step #(.STATE_W(32), .POLY(32'h04c11db7), .GALOIS(1'b1), .FEED_FWD(1'b0), .REVERSE(1'b1), .DATA_W(8))
    u_crc (.data_in(c_di), .state_in(c_si), .data_out(c_do), .state_out(c_so));
  lfsr_step #(.STATE_W(16), .POLY(16'h8005), .GALOIS(1'b1), .FEED_FWD(1'b0), .REVERSE(1'b0), .DATA_W(1))
    u_g1 (.data_in(d_di), .state_in(d_si), .data_out(d_do), .state_out(d_so));
  lfsr_step #(.STATE_W(58), .POLY(58'h8000000001), .GALOIS(1'b0), .FEED_FWD(1'b1), .REVERSE(1'b1), .DATA_W(64))
    u_ff (.data_in(e_di), .state_in(e_si), .data_out(e_do), .state_out(e_so));
  lfsr_step #(.STATE_W(23), .POLY(23'h210125), .GALOIS(1'b1), .FEED_FWD(1'b1), .REVERSE(1'b0), .DATA_W(64))
    u_gf (.data_in(f_di), .state_in(f_si), .data_out(f_do), .state_out(f_so));
  lfsr_step #(.STATE_W(7), .POLY(7'h41), .GALOIS(1'b0), .FEED_FWD(1'b0), .REVERSE(1'b0), .DATA_W(1))
    u_f1 (.data_in(g_di), .state_in(g_si), .data_out(g_do), .state_out(g_so));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bit-serial reference, one step at a time
  function automatic void ref_run(input int w, input logic [63:0] poly, input bit gal,
                                  input bit ff, input bit rv, input int dw,
                                  input logic [63:0] si, input logic [63:0] di,
                                  output logic [63:0] so, output logic [63:0] dout);
    logic [63:0] st, d, o, mask;
    logic b, fb, ob, inj;
    st = '0; d = '0; o = '0; so = '0; dout = '0;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    for (int k = 0; k < w; k++)  st[k] = rv ? si[w-1-k] : si[k];
    for (int k = 0; k < dw; k++) d[k]  = rv ? di[dw-1-k] : di[k];
    for (int i = 0; i < dw; i++) begin
      b = d[dw-1-i];
      if (gal) fb = st[w-1];
      else begin
        fb = 1'b0;
        for (int k = 0; k < w; k++)
          if (poly[k]) fb = fb ^ st[(k == 0) ? w-1 : k-1];
      end
      ob  = fb ^ b;
      inj = ff ? b : ob;
      st  = (st << 1) & mask;
      st[0] = inj;
      if (gal)
        for (int k = 1; k < w; k++)
          if (poly[k]) st[k] = st[k] ^ inj;
      o[dw-1-i] = ob;
    end
    for (int k = 0; k < w; k++)  so[k]   = rv ? st[w-1-k] : st[k];
    for (int k = 0; k < dw; k++) dout[k] = rv ? o[dw-1-k] : o[k];
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic zero_all();
    a_si = '0; a_di = '0; b_si = '0; b_di = '0; c_si = '0; c_di = '0;
    d_si = '0; d_di = '0; e_si = '0; e_di = '0; f_si = '0; f_di = '0;
    g_si = '0; g_di = '0;
  endtask

  task automatic random_cycle(input bit zero_data);
    logic [63:0] es, ed;
    @(posedge clk);
    a_si = rnd64()[30:0]; a_di = zero_data ? '0 : rnd64()[7:0];
    b_si = rnd64()[8:0];  b_di = zero_data ? '0 : rnd64();
    c_si = rnd64()[31:0]; c_di = zero_data ? '0 : rnd64()[7:0];
    d_si = rnd64()[15:0]; d_di = zero_data ? '0 : rnd64()[0:0];
    e_si = rnd64()[57:0]; e_di = zero_data ? '0 : rnd64();
    f_si = rnd64()[22:0]; f_di = zero_data ? '0 : rnd64();
    g_si = rnd64()[6:0];  g_di = zero_data ? '0 : rnd64()[0:0];
    @(negedge clk);
    ref_run(31, 64'h10000001, 0, 0, 0, 8, 64'(a_si), 64'(a_di), es, ed);
    check("R2 R7 fib31x8 state", 64'(a_so), es);  check("R2 R7 fib31x8 data", 64'(a_do), ed);
    ref_run(9, 64'h021, 0, 0, 0, 64, 64'(b_si), b_di, es, ed);
    check("R1 R7 fib9x64 state", 64'(b_so), es);  check("R1 R7 fib9x64 data", b_do, ed);
    ref_run(32, 64'h04c11db7, 1, 0, 1, 8, 64'(c_si), 64'(c_di), es, ed);
    check("R6 R7 gal32rx8 state", 64'(c_so), es); check("R6 R7 gal32rx8 data", 64'(c_do), ed);
    ref_run(16, 64'h8005, 1, 0, 0, 1, 64'(d_si), 64'(d_di), es, ed);
    check("R3 R7 gal16x1 state", 64'(d_so), es);  check("R3 R7 gal16x1 data", 64'(d_do), ed);
    ref_run(58, 64'h8000000001, 0, 1, 1, 64, 64'(e_si), e_di, es, ed);
    check("R4 R6 ff58rx64 state", 64'(e_so), es); check("R4 R6 ff58rx64 data", e_do, ed);
    ref_run(23, 64'h210125, 1, 1, 0, 64, 64'(f_si), f_di, es, ed);
    check("R4 R7 gff23x64 state", 64'(f_so), es); check("R4 R7 gff23x64 data", f_do, ed);
    ref_run(7, 64'h41, 0, 0, 0, 1, 64'(g_si), 64'(g_di), es, ed);
    check("R5 R7 fib7x1 state", 64'(g_so), es);   check("R5 R7 fib7x1 data", 64'(g_do), ed);
  endtask

  initial begin
    string msg;
    logic [30:0] st31;
    logic [8:0]  st9;
    logic [31:0] crc;
    logic [31:0] r31;
    logic [8:0]  r9;
    logic [63:0] exp64;

    zero_all();
    // R10: all-zero inputs stay zero in every configuration
    @(negedge clk);
    check("R10 zero A", {a_so, 25'(0), a_do}, '0);
    check("R10 zero B", 64'(b_so) | b_do, '0);
    check("R10 zero C", {c_so, 24'(0), c_do}, '0);
    check("R10 zero D", 64'(d_so) | 64'(d_do), '0);
    check("R10 zero E", 64'(e_so) | e_do, '0);
    check("R10 zero F", 64'(f_so) | f_do, '0);
    check("R10 zero G", 64'(g_so) | 64'(g_do), '0);

    // R1 R2 R5: single Fibonacci step by hand: state 7'b1000000, tap stages 6 and 5
    @(posedge clk);
    g_si = 7'b1000000; g_di = 1'b0;
    @(negedge clk);
    check("R1 R2 fib7 hand state", 64'(g_so), 64'h01);
    check("R1 R2 fib7 hand data",  64'(g_do), 64'h1);

    // R3: single Galois step, top set, no input: 0x8005 injected
    @(posedge clk);
    d_si = 16'h8000; d_di = 1'b0;
    @(negedge clk);
    check("R3 gal16 hand state", 64'(d_so), 64'h8005);
    check("R3 gal16 hand data",  64'(d_do), 64'h1);

    // R7: random comparisons, with and without input data
    for (int n = 0; n < 200; n++) random_cycle(1'b0);
    for (int n = 0; n < 50; n++)  random_cycle(1'b1);

    // R8: PRBS31 stream, bytes chained through state_out
    zero_all();
    st31 = '1; r31 = 32'h7fffffff;
    for (int n = 0; n < 512; n++) begin
      @(posedge clk);
      a_si = st31; a_di = '0;
      for (int s = 0; s < 8; s++)
        r31 = (((r31 >> 27) ^ (r31 >> 30)) & 32'd1) | ((r31 & 32'h3fffffff) << 1);
      @(negedge clk);
      check("R8 prbs31 byte", 64'(a_do), 64'(r31[7:0]));
      st31 = a_so;
    end

    // R8: PRBS9 stream, eight bytes per evaluation, first byte in the top
    st9 = '1; r9 = 9'h1ff;
    for (int n = 0; n < 256; n++) begin
      @(posedge clk);
      b_si = st9; b_di = '0;
      exp64 = '0;
      for (int by = 0; by < 8; by++) begin
        for (int s = 0; s < 8; s++)
          r9 = {r9[7:0], r9[4] ^ r9[8]};
        exp64 = {exp64[55:0], r9[7:0]};
      end
      @(negedge clk);
      check("R8 prbs9 word", b_do, exp64);
      st9 = b_so;
    end

    // R9: CRC32 of "123456789"
    msg = "123456789";
    crc = '1;
    for (int n = 0; n < msg.len(); n++) begin
      @(posedge clk);
      c_si = crc; c_di = msg[n];
      @(negedge clk);
      crc = c_so;
    end
    check("R9 crc32 residue", 64'(crc), 64'h340BC6D9);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule